// File: doc/BRIEF.md
# Sleep/Active Power-Mode Controller

This block decides whether a motor-driver chip is in its low-power sleep state or in its active state. It runs on the system clock. All of its timing is counted in pulses of a slow time base, which is normally a 100 kHz tick. It watches three inputs, which arrive already synchronised:

- a high-voltage enable pin;
- a keep-alive level driven by the host controller;
- the received bus level of the LIN transceiver.

From these it drives the active-mode indication, the enables for the host regulator, the watchdog and the battery-measurement switch, and a flag that tells the host what caused the last wake-up.

There are two wake paths, and each has its own filter. The enable pin must stay high for a short debounce. The bus must stay dominant (low) for a longer, uninterrupted interval. The host keep-alive cannot wake the device. It can only send the device back to sleep, and only through a qualified sequence: the level must first be validly high and then stay low for a set time. A wake condition that is already qualified holds off a pending sleep request. Every filter length is a parameter counted in ticks.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After reset the controller is active (active_o = 1), all enables are high and wake_lin_o = 0.
- R2: In sleep, en2_i high for EN2_TICKS consecutive ticks wakes the device. A shorter high pulse leaves it asleep.
- R3: In sleep, lin_rx_i low (0 = dominant) for LIN_TICKS consecutive ticks wakes the device. Any tick at which lin_rx_i is high restarts the count, so two separate low stretches that are each shorter than LIN_TICKS do not wake it.
- R4: In sleep, en1_i has no effect: holding it high for any time does not wake the device.
- R5: In active, the device goes to sleep only after en1_i has been high for EN1_HI_TICKS ticks and then low for EN1_LO_TICKS consecutive ticks. A high pulse shorter than EN1_HI_TICKS does not arm this sequence.
- R6: After a wake-up caused by the bus, the device stays active while en1_i and en2_i are low.
- R7: wake_lin_o becomes 1 on a wake-up caused by the bus and stays 0 on a wake-up caused by en2_i. It holds its value until trig_ok_i is high at a clock edge, which clears it.
- R8: vcc_en_o, wdog_en_o and batsw_en_o are 1 in active and 0 in sleep.
- R9: While a wake condition is qualified, a pending sleep request is held off. Sleep follows once that condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time-base pulse (100 kHz nominal) |
| en2_i | input | 1 | High-voltage enable level, high = wake |
| en1_i | input | 1 | Host keep-alive level |
| lin_rx_i | input | 1 | Received bus level, 0 = dominant |
| trig_ok_i | input | 1 | First valid watchdog trigger accepted; clears the wake flag |
| active_o | output | 1 | 1 = active mode, 0 = sleep |
| vcc_en_o | output | 1 | Host regulator enable |
| wdog_en_o | output | 1 | Watchdog enable |
| batsw_en_o | output | 1 | Battery-measurement switch enable |
| wake_lin_o | output | 1 | 1 = last wake-up came from the bus |

## Verification
The wake paths are driven with pulses that are one tick shorter than their filter and with pulses that are long enough. For the bus path there is also a pair of short dominant stretches split by a recessive gap. Together these separate a filter that counts consecutive ticks from one that accumulates ticks. The keep-alive is driven in sleep, with a short high pulse, and with a full high-then-low sequence. This shows that it cannot wake the device and that it arms sleep only after a qualified high. An overlap of the enable-pin wake with a completed sleep sequence checks the priority rule. The sequence of an enable-pin wake, then a bus wake, then a trigger shows how the wake flag is set and cleared.

// File: rtl/pm_mode_pkg.sv
package pm_mode_pkg;
  typedef enum logic {
    PM_SLEEP  = 1'b0,
    PM_ACTIVE = 1'b1
  } pm_mode_e;
endpackage

// File: rtl/pm_hold_filter.sv
// Counts ticks while level_i stays high; done once LEN ticks are reached.
module pm_hold_filter #(
  parameter int unsigned LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  input  logic level_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!arm_i || !level_i)   cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  // R3
  count_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pm_sleep_seq.sv
// Qualified high-then-low sequence on the host keep-alive.
module pm_sleep_seq #(
  parameter int unsigned HI_TICKS = 2,
  parameter int unsigned LO_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic active_i,
  input  logic en1_i,
  output logic sleep_req_o
);
  logic hi_done, armed_q;

  pm_hold_filter #(.LEN(HI_TICKS)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .arm_i(active_i), .level_i(en1_i), .done_o(hi_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (!active_i) armed_q <= 1'b0;
    else if (hi_done)   armed_q <= 1'b1;
  end

  pm_hold_filter #(.LEN(LO_TICKS)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .arm_i(active_i && armed_q), .level_i(!en1_i), .done_o(sleep_req_o)
  );

  // R5
  arm_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(en1_i));

  // R4
  no_arm_in_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i) |=> !armed_q);
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
  import pm_mode_pkg::*;
#(
  parameter int unsigned EN2_TICKS    = 2,
  parameter int unsigned LIN_TICKS    = 7,
  parameter int unsigned EN1_HI_TICKS = 2,
  parameter int unsigned EN1_LO_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en2_i,
  input  logic en1_i,
  input  logic lin_rx_i,
  input  logic trig_ok_i,
  output logic active_o,
  output logic vcc_en_o,
  output logic wdog_en_o,
  output logic batsw_en_o,
  output logic wake_lin_o
);
  pm_mode_e mode_q, mode_d;
  logic en2_done, lin_done, wake_req, sleep_req, wake_lin_q;

  pm_hold_filter #(.LEN(EN2_TICKS)) u_en2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .arm_i(1'b1), .level_i(en2_i), .done_o(en2_done)
  );

  pm_hold_filter #(.LEN(LIN_TICKS)) u_lin (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .arm_i(1'b1), .level_i(!lin_rx_i), .done_o(lin_done)
  );

  pm_sleep_seq #(.HI_TICKS(EN1_HI_TICKS), .LO_TICKS(EN1_LO_TICKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .active_i(mode_q == PM_ACTIVE), .en1_i(en1_i), .sleep_req_o(sleep_req)
  );

  assign wake_req = en2_done | lin_done;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_ACTIVE: if (sleep_req && !wake_req) mode_d = PM_SLEEP;
      PM_SLEEP:  if (wake_req)               mode_d = PM_ACTIVE;
      default:   mode_d = PM_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_ACTIVE;
    else         mode_q <= mode_d;
  end

  // Wake source: bus only when the enable pin did not qualify too.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      wake_lin_q <= 1'b0;
    else if (mode_q == PM_SLEEP && mode_d == PM_ACTIVE)
      wake_lin_q <= lin_done && !en2_done;
    else if (mode_q == PM_ACTIVE && mode_d == PM_SLEEP)
      wake_lin_q <= 1'b0;
    else if (trig_ok_i)
      wake_lin_q <= 1'b0;
  end

  assign active_o   = (mode_q == PM_ACTIVE);
  assign vcc_en_o   = active_o;
  assign wdog_en_o  = active_o;
  assign batsw_en_o = active_o;
  assign wake_lin_o = wake_lin_q;

  // R2
  wake_needs_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(en2_done || lin_done));

  // R4
  stay_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !en2_done && !lin_done) |=> !active_o);

  // R9
  wake_blocks_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && (en2_done || lin_done)) |=> active_o);

  // R5
  sleep_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(sleep_req));

  // R7
  flag_set_on_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_lin_o) |-> $past(!active_o && lin_done));

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_ok_i && active_o) |=> !wake_lin_o);
endmodule

// File: tb/pm_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pm_mode_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic en2 = 1'b0, en1 = 1'b0, lin = 1'b1, trig = 1'b0;
  logic active, vcc_en, wdog_en, batsw_en, wake_lin;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pm_mode_ctrl #(.EN2_TICKS(2), .LIN_TICKS(7), .EN1_HI_TICKS(2), .EN1_LO_TICKS(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en2_i(en2), .en1_i(en1),
    .lin_rx_i(lin), .trig_ok_i(trig), .active_o(active), .vcc_en_o(vcc_en),
    .wdog_en_o(wdog_en), .batsw_en_o(batsw_en), .wake_lin_o(wake_lin)
  );

  // tick every 5 clocks, driven at negedge
  initial begin
    forever begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        tick = (i == 4);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // wait n ticks, then one more clock so the mode register settles
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mode(input logic exp, input string tag);
    chk(active, exp, tag);
    chk(vcc_en, exp, {tag, " R8 vcc"});
    chk(wdog_en, exp, {tag, " R8 wdog"});
    chk(batsw_en, exp, {tag, " R8 batsw"});
  endtask

  task automatic t_reset();
    chk_mode(1'b1, "R1 reset active");
    chk(wake_lin, 1'b0, "R1 reset flag");
  endtask

  task automatic t_enter_sleep(input string tag);
    en1 = 1'b1; tk(2);
    en1 = 1'b0; tk(1);
    chk(active, 1'b1, {tag, " R5 one low tick"});
    tk(1);
    chk_mode(1'b0, {tag, " R5 asleep"});
  endtask

  task automatic t_en1_in_sleep();
    en1 = 1'b1; tk(10);
    chk(active, 1'b0, "R4 en1 high in sleep");
    en1 = 1'b0; tk(4);
    chk(active, 1'b0, "R4 en1 fall in sleep");
  endtask

  task automatic t_en2_wake();
    en2 = 1'b1; tk(1); en2 = 1'b0; tk(4);
    chk(active, 1'b0, "R2 short en2 ignored");
    en2 = 1'b1; tk(1);
    chk(active, 1'b0, "R2 one tick not yet");
    tk(1);
    chk_mode(1'b1, "R2 en2 wake");
    chk(wake_lin, 1'b0, "R7 en2 wake flag");
    en2 = 1'b0; tk(1);
  endtask

  task automatic t_lin_wake();
    lin = 1'b0; tk(5); lin = 1'b1; tk(1);
    lin = 1'b0; tk(5); lin = 1'b1; tk(2);
    chk(active, 1'b0, "R3 split low ignored");
    lin = 1'b0; tk(6);
    chk(active, 1'b0, "R3 six ticks not yet");
    tk(1);
    chk_mode(1'b1, "R3 lin wake");
    chk(wake_lin, 1'b1, "R7 lin wake flag");
    lin = 1'b1; tk(10);
    chk(active, 1'b1, "R6 stays active");
    chk(wake_lin, 1'b1, "R7 flag held");
    trig = 1'b1; @(negedge clk); trig = 1'b0; @(negedge clk);
    chk(wake_lin, 1'b0, "R7 flag cleared");
  endtask

  task automatic t_short_en1();
    en1 = 1'b1; tk(1);
    en1 = 1'b0; tk(6);
    chk(active, 1'b1, "R5 short en1 not armed");
  endtask

  task automatic t_priority();
    en2 = 1'b1; en1 = 1'b1; tk(3);
    en1 = 1'b0; tk(5);
    chk(active, 1'b1, "R9 held by en2");
    en2 = 1'b0;
    repeat (3) @(negedge clk);
    chk_mode(1'b0, "R9 sleep after en2 drop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enter_sleep("first");
    t_en1_in_sleep();
    t_en2_wake();
    t_enter_sleep("second");
    t_lin_wake();
    t_short_en1();
    t_priority();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule